// File: doc/BRIEF.md
# Quarter-Wave Sine Reference Generator

This block supplies the set-point for a digitally controlled inverter loop. On every sampling tick it emits one sample of a 50 Hz sine wave, written as a magnitude in machine units and a separate sign flag. The amplitude is an input. Each output sample is the amplitude multiplied by the sine of the current phase step.

Only a quarter period of the sine is held on chip. The table is computed while the design is elaborated, so no file is read. The other three quarters are made by reading the table in reverse and by setting the sign flag. Parameter `QLOG2` sets the quarter length to 64, 128 or 256 entries. This matches sampling rates of 12.8, 25.6 or 51.2 kHz. The table resolution is the coarsest quantization in the loop.

Top module: `sine_ref_gen`

## Requirements
- R1: A synchronous reset, `rst` high at a clock edge, clears `ref_mag` to 0, `ref_neg` to 0 and `ref_vld` to 0, and returns the phase step to 0.
- R2: At an edge where `tick` is low and `rst` is low, the phase step does not move, `ref_vld` is 0, and `ref_mag` and `ref_neg` keep their values.
- R3: A `tick` sampled high at an edge makes `ref_vld` 1 after that same edge. The sample is scaled by the `amp` value present at that edge, and the phase step then advances by one.
- R4: The table has Q = 2^QLOG2 entries. Entry k is round((2^TW-1)·sin(π·k/(2Q))). For steps i = 0..Q-1 the sample uses entry i, and `ref_neg` is 0.
- R5: For steps i = Q+o, with o = 0..Q-1, the sample uses entry Q-o, read in reverse. When o = 0 the peak value 2^TW-1 is used in place of entry Q.
- R6: Steps 2Q..4Q-1 give the same magnitudes as steps 0..2Q-1. Whenever that magnitude is nonzero, `ref_neg` is 1.
- R7: An emitted magnitude of 0 always has `ref_neg` equal to 0. This holds at steps 0 and 2Q, and whenever `amp` is 0.
- R8: After 4Q ticks the phase step wraps to 0, so tick number 4Q+1 repeats the step 0 sample.
- R9: When `rst` and `tick` are both high at one edge, the reset wins. No sample is emitted (`ref_vld` is 0), and the next tick emits step 0.
- R10: `ref_mag` = (t·amp + 2^(TW-1)) >> TW, where t is the selected table value. It never exceeds `amp`, and at the peak it equals `amp` whenever amp ≤ 2^(TW-1).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| tick | input | 1 | Sampling strobe; one sample per high cycle |
| amp | input | AW | Peak amplitude in machine units |
| ref_mag | output | AW | Magnitude of the reference sample |
| ref_neg | output | 1 | Sign flag, 1 for a negative sample |
| ref_vld | output | 1 | High for one cycle after each accepted tick |

## Verification
Reset and the sampling tick can land on the same clock edge. The bench forces this on purpose: after the phase has advanced part way, it raises `rst` and `tick` in the same cycle. It then requires that no sample appears and that the next lone tick emits step 0. A change of `amp` can also coincide with a tick. The bench changes the amplitude on the tick cycle itself and requires that the new value scales that very sample. Both cases are compared against sine values computed in floating point by the bench.

// File: rtl/sine_ref_gen.sv
module sine_ref_gen #(
  parameter int QLOG2 = 7,
  parameter int TW    = 16,
  parameter int AW    = 12
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          tick,
  input  logic [AW-1:0] amp,
  output logic [AW-1:0] ref_mag,
  output logic          ref_neg,
  output logic          ref_vld
);
  localparam int Q  = 1 << QLOG2;
  localparam int IW = QLOG2 + 2;
  localparam int PW = TW + AW;
  localparam logic [TW-1:0] TPEAK = '1;
  localparam logic [PW-1:0] HALF  = PW'(1) << (TW - 1);
  localparam real PI = 3.14159265358979323846;

  function automatic logic [TW-1:0] qsin(input int k);
    real x;
    x = $sin(PI * k / (2.0 * Q)) * real'(TPEAK) + 0.5;
    return TW'($rtoi(x));
  endfunction

  if (QLOG2 < 6 || QLOG2 > 8) begin : g_bad
    $error("QLOG2 must be 6, 7 or 8");
  end

  logic [TW-1:0] tbl [Q];
  for (genvar k = 0; k < Q; k++) begin : g_tbl
    localparam logic [TW-1:0] TV = qsin(k);
    assign tbl[k] = TV;
  end

  logic [IW-1:0] idx;

  wire [1:0]       quad    = idx[IW-1 -: 2];
  wire [QLOG2-1:0] off     = idx[QLOG2-1:0];
  wire [QLOG2-1:0] rev     = QLOG2'(0) - off;
  wire             at_peak = quad[0] && (off == '0);
  wire [TW-1:0]    tsel    = at_peak ? TPEAK : tbl[quad[0] ? rev : off];
  wire [PW-1:0]    prod    = PW'(tsel) * PW'(amp) + HALF;
  wire [AW-1:0]    scaled  = prod[PW-1:TW];

  always_ff @(posedge clk) begin
    if (rst) begin
      idx     <= '0;
      ref_mag <= '0;
      ref_neg <= 1'b0;
      ref_vld <= 1'b0;
    end else if (tick) begin
      idx     <= idx + 1'b1;
      ref_mag <= scaled;
      ref_neg <= quad[1] && (scaled != '0);
      ref_vld <= 1'b1;
    end else begin
      ref_vld <= 1'b0;
    end
  end
endmodule

// File: rtl/sine_ref_gen_chk.sv
module sine_ref_gen_chk #(
  parameter int AW = 12
) (
  input logic          clk,
  input logic          rst,
  input logic          tick,
  input logic [AW-1:0] amp,
  input logic [AW-1:0] ref_mag,
  input logic          ref_neg,
  input logic          ref_vld
);
  a_r1_reset_clears: assert property (@(posedge clk)
    rst |=> (!ref_vld && ref_mag == '0 && !ref_neg));

  a_r2_idle_holds: assert property (@(posedge clk) disable iff (rst)
    !tick |=> (!ref_vld && $stable(ref_mag) && $stable(ref_neg)));

  a_r3_tick_gives_valid: assert property (@(posedge clk) disable iff (rst)
    tick |=> ref_vld);

  a_r7_zero_unsigned: assert property (@(posedge clk) disable iff (rst)
    (ref_vld && ref_mag == '0) |-> !ref_neg);

  a_r10_within_amp: assert property (@(posedge clk) disable iff (rst)
    ref_vld |-> (ref_mag <= $past(amp)));
endmodule

bind sine_ref_gen sine_ref_gen_chk #(.AW(AW)) u_chk (
  .clk(clk), .rst(rst), .tick(tick), .amp(amp),
  .ref_mag(ref_mag), .ref_neg(ref_neg), .ref_vld(ref_vld)
);

// File: tb/sine_ref_gen_bench.sv
`timescale 1ns/1ps
module sine_ref_gen_bench;
  localparam int QLOG2 = 7;
  localparam int TW = 16;
  localparam int AW = 12;
  localparam int Q = 1 << QLOG2;
  localparam int N = 4 * Q;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic tick = 1'b0;
  logic [AW-1:0] amp = '0;
  logic [AW-1:0] ref_mag;
  logic ref_neg, ref_vld;

  int checks = 0;
  int errors = 0;
  int eidx = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  sine_ref_gen #(.QLOG2(QLOG2), .TW(TW), .AW(AW)) u_sine_ref_gen (
    .clk(clk), .rst(rst), .tick(tick), .amp(amp),
    .ref_mag(ref_mag), .ref_neg(ref_neg), .ref_vld(ref_vld)
  );

  function automatic int qtab(input int k);
    real x;
    x = $sin(3.14159265358979323846 * k / (2.0 * Q)) * 65535.0 + 0.5;
    return $rtoi(x);
  endfunction

  function automatic int emag(input int i, input int a);
    int q, o, k;
    q = i / Q; o = i % Q;
    k = (q % 2 == 0) ? o : Q - o;
    return (qtab(k) * a + (1 << (TW - 1))) >> TW;
  endfunction

  function automatic int eneg(input int i, input int a);
    return (i >= 2 * Q && emag(i, a) != 0) ? 1 : 0;
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic check_sample(input string req, input int i, input int a);
    chk(ref_vld == 1'b1, {req, " valid"}, int'(ref_vld), 1);
    chk(int'(ref_mag) == emag(i, a), {req, " magnitude"}, int'(ref_mag), emag(i, a));
    chk(int'(ref_neg) == eneg(i, a), {req, " sign"}, int'(ref_neg), eneg(i, a));
  endtask

  task automatic pulse(input int a);
    @(negedge clk); amp = AW'(a); tick = 1'b1;
    @(negedge clk); tick = 1'b0;
  endtask

  task automatic t_reset;
    rst = 1'b1;
    repeat (3) @(negedge clk);
    chk(ref_vld == 1'b0, "R1 valid", int'(ref_vld), 0);
    chk(ref_mag == '0, "R1 magnitude", int'(ref_mag), 0);
    chk(ref_neg == 1'b0, "R1 sign", int'(ref_neg), 0);
    rst = 1'b0;
    eidx = 0;
  endtask

  task automatic t_sweep;
    for (int i = 0; i < N; i++) begin
      pulse(2000);
      if (i < Q) check_sample("R4", eidx, 2000);
      else if (i < 2 * Q) check_sample("R5", eidx, 2000);
      else check_sample("R6", eidx, 2000);
      if (i == Q) chk(ref_mag == AW'(2000), "R10 peak", int'(ref_mag), 2000);
      if (i == 0 || i == 2 * Q) chk(ref_neg == 1'b0, "R7 zero sign", int'(ref_neg), 0);
      eidx = (eidx + 1) % N;
    end
    pulse(2000);
    chk(eidx == 0, "R8 bench index", eidx, 0);
    check_sample("R8 wrap", 0, 2000);
    eidx = 1;
  endtask

  task automatic t_idle;
    logic [AW-1:0] held;
    pulse(1500);
    check_sample("R3", eidx, 1500);
    eidx++;
    held = ref_mag;
    for (int c = 0; c < 4; c++) begin
      @(negedge clk);
      chk(ref_vld == 1'b0, "R2 valid", int'(ref_vld), 0);
      chk(ref_mag == held, "R2 hold", int'(ref_mag), int'(held));
    end
    pulse(1500);
    check_sample("R2 no advance", eidx, 1500);
    eidx++;
  endtask

  task automatic t_amp;
    pulse(0);
    check_sample("R7 amp zero", eidx, 0);
    chk(ref_neg == 1'b0, "R7 sign", int'(ref_neg), 0);
    eidx++;
    while (eidx != 3 * Q) begin
      pulse(100);
      eidx = (eidx + 1) % N;
    end
    pulse(4095);
    check_sample("R3 amp on tick", 3 * Q, 4095);
    chk(ref_mag == AW'(4095), "R10 peak max", int'(ref_mag), 4095);
    chk(ref_neg == 1'b1, "R6 negative peak", int'(ref_neg), 1);
    eidx++;
  endtask

  task automatic t_burst;
    @(negedge clk); amp = AW'(3000); tick = 1'b1;
    for (int c = 0; c < 6; c++) begin
      @(negedge clk);
      check_sample("R3 back to back", eidx, 3000);
      eidx = (eidx + 1) % N;
    end
    tick = 1'b0;
  endtask

  task automatic t_reset_tick;
    @(negedge clk); rst = 1'b1; tick = 1'b1; amp = AW'(2500);
    @(negedge clk); rst = 1'b0; tick = 1'b0;
    chk(ref_vld == 1'b0, "R9 no sample", int'(ref_vld), 0);
    chk(ref_mag == '0, "R9 magnitude", int'(ref_mag), 0);
    eidx = 0;
    pulse(2500);
    check_sample("R9 restart", 0, 2500);
    pulse(2500);
    check_sample("R9 next", 1, 2500);
  endtask

  initial begin
    t_reset();
    t_sweep();
    t_idle();
    t_amp();
    t_burst();
    t_reset_tick();
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule